// File: doc/BRIEF.md
# Three-Port Bidirectional GPIO Register Block

This block holds the CPU-visible registers and drives the pin controls for three general-purpose ports: ports A and B are eight bits wide and port C is four bits wide. Every pin has a data latch, a direction bit and a pull-up enable bit. The top pin of port C has two extra functions. It can be switched to open-drain drive, and it can serve as a falling-edge external interrupt source. The interrupt path works whatever the pin's direction or drive mode is.

The CPU uses a simple synchronous bus. A write strobe commits the write data on the next rising clock edge. While the read strobe is high, read data is presented combinationally. Each pin is modelled as four signals: a pad input, an output enable, an output value and a pull-up enable. Before any pad input is used, it passes through a two-flop synchronizer.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, all direction, data latch, pull-up and control registers read 0. Every output enable and pull-up enable is 0, and the interrupt request is 0.
- R2: A direction bit of 1 asserts that pin's output enable and drives the pin's data latch bit onto its output value. A direction bit of 0 deasserts the output enable.
- R3: A read of a data register returns the latch bit for pins whose direction bit is 1. It does not return the pad level.
- R4: A read of a data register returns the pad level for pins whose direction bit is 0. A pad change is seen on the second rising edge after it occurs, and not on the first.
- R5: A write to the data bit of an input pin stores the value in the latch without enabling the output. The stored value is driven once the direction bit is set.
- R6: Address map. Data registers are at 0x00, 0x01 and 0x02 (ports A, B, C). Direction registers are at 0x04, 0x05 and 0x06. Pull-up registers are at 0x10, 0x11 and 0x12. The control register is at 0x13, with bit 0 = open-drain enable for port C bit 3 and bit 1 = interrupt enable. All of these read back what was written. Unmapped addresses read 0, and read data is 0 while the read strobe is low.
- R7: Each pull-up enable output equals its pull-up register bit.
- R8: Bits 7:4 of the port C data, direction and pull-up registers read as 0, and writes to those bits are ignored.
- R9: With open-drain enabled and port C bit 3 set as an output, the pin is never driven high. Its output enable is asserted only while its latch bit is 0, and its output value is 0. Its pull-up enable still follows its pull-up bit.
- R10: With interrupt enable set, a falling edge of the synchronized port C bit 3 level produces a one-cycle interrupt request pulse. The pulse appears on the third rising edge after the pad falls, in any direction or drive mode. A rising edge produces no pulse, and no pulse occurs while interrupt enable is 0. The port C direction register remains readable and writable while interrupts are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_re is high |
| pa_in | input | 8 | Port A pad levels |
| pa_oe | output | 8 | Port A output enables |
| pa_out | output | 8 | Port A output values |
| pa_pu | output | 8 | Port A pull-up enables |
| pb_in | input | 8 | Port B pad levels |
| pb_oe | output | 8 | Port B output enables |
| pb_out | output | 8 | Port B output values |
| pb_pu | output | 8 | Port B pull-up enables |
| pc_in | input | 4 | Port C pad levels |
| pc_oe | output | 4 | Port C output enables |
| pc_out | output | 4 | Port C output values |
| pc_pu | output | 4 | Port C pull-up enables |
| irq_req | output | 1 | One-cycle external interrupt request |

## Verification
The data read path is exercised with three direction patterns: all outputs, all inputs, and a split nibble on port A. With all outputs, the latch is read; with all inputs, the pad is read; the split pattern, with pad and latch set to complementary values, shows any bit that takes the wrong source. The pad-input timing is tested by reading once after one edge and again after two edges, which separates the correct two-flop latency from a one-flop or three-flop one. Port C bit 3 is tested with the latch at both 0 and 1 and with open-drain both on and off, so a push-pull drive is distinguished from a low-only drive. The interrupt is tested with a falling edge, a rising edge and a falling edge while disabled, each watched over several cycles, so pulse timing, pulse width and edge polarity are all checked.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_oe,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_pu,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_oe,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_pu,
  input  logic [CW-1:0] pc_in,
  output logic [CW-1:0] pc_oe,
  output logic [CW-1:0] pc_out,
  output logic [CW-1:0] pc_pu,
  output logic          irq_req
);
  localparam int SW = 2*DW + CW;
  localparam logic [AW-1:0] A_DAT_A = AW'('h00);
  localparam logic [AW-1:0] A_DAT_B = AW'('h01);
  localparam logic [AW-1:0] A_DAT_C = AW'('h02);
  localparam logic [AW-1:0] A_DIR_A = AW'('h04);
  localparam logic [AW-1:0] A_DIR_B = AW'('h05);
  localparam logic [AW-1:0] A_DIR_C = AW'('h06);
  localparam logic [AW-1:0] A_PU_A  = AW'('h10);
  localparam logic [AW-1:0] A_PU_B  = AW'('h11);
  localparam logic [AW-1:0] A_PU_C  = AW'('h12);
  localparam logic [AW-1:0] A_CTL   = AW'('h13);

  logic [DW-1:0] lat_a, lat_b, dir_a, dir_b, pu_a, pu_b;
  logic [CW-1:0] lat_c, dir_c, pu_c;
  logic          od_en, irq_en;
  logic [SW-1:0] meta, sync;
  logic          c3_d;

  wire [DW-1:0] sa = sync[DW-1:0];
  wire [DW-1:0] sb = sync[2*DW-1:DW];
  wire [CW-1:0] sc = sync[SW-1:2*DW];
  wire          c3 = sc[CW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_a <= '0; lat_b <= '0; lat_c <= '0;
      dir_a <= '0; dir_b <= '0; dir_c <= '0;
      pu_a  <= '0; pu_b  <= '0; pu_c  <= '0;
      od_en <= 1'b0; irq_en <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DAT_A: lat_a <= bus_wdata;
        A_DAT_B: lat_b <= bus_wdata;
        A_DAT_C: lat_c <= bus_wdata[CW-1:0];
        A_DIR_A: dir_a <= bus_wdata;
        A_DIR_B: dir_b <= bus_wdata;
        A_DIR_C: dir_c <= bus_wdata[CW-1:0];
        A_PU_A:  pu_a  <= bus_wdata;
        A_PU_B:  pu_b  <= bus_wdata;
        A_PU_C:  pu_c  <= bus_wdata[CW-1:0];
        A_CTL: begin
          od_en  <= bus_wdata[0];
          irq_en <= bus_wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta    <= '0;
      sync    <= '0;
      c3_d    <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      meta    <= {pc_in, pb_in, pa_in};
      sync    <= meta;
      c3_d    <= c3;
      irq_req <= irq_en & c3_d & ~c3;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        A_DAT_A: bus_rdata = (dir_a & lat_a) | (~dir_a & sa);
        A_DAT_B: bus_rdata = (dir_b & lat_b) | (~dir_b & sb);
        A_DAT_C: bus_rdata[CW-1:0] = (dir_c & lat_c) | (~dir_c & sc);
        A_DIR_A: bus_rdata = dir_a;
        A_DIR_B: bus_rdata = dir_b;
        A_DIR_C: bus_rdata[CW-1:0] = dir_c;
        A_PU_A:  bus_rdata = pu_a;
        A_PU_B:  bus_rdata = pu_b;
        A_PU_C:  bus_rdata[CW-1:0] = pu_c;
        A_CTL:   bus_rdata[1:0] = {irq_en, od_en};
        default: ;
      endcase
    end
  end

  assign pa_oe  = dir_a;
  assign pa_out = lat_a;
  assign pa_pu  = pu_a;
  assign pb_oe  = dir_b;
  assign pb_out = lat_b;
  assign pb_pu  = pu_b;
  assign pc_oe  = {dir_c[CW-1] & ~(od_en & lat_c[CW-1]), dir_c[CW-2:0]};
  assign pc_out = {lat_c[CW-1] & ~od_en, lat_c[CW-2:0]};
  assign pc_pu  = pu_c;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pa_pu,
  input logic [CW-1:0] pc_oe,
  input logic [CW-1:0] pc_out,
  input logic          od_en,
  input logic          irq_en,
  input logic [CW-1:0] dir_c,
  input logic          irq_req
);
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h04)) |=> (pa_oe == $past(bus_wdata)));

  assert_pullup_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h10)) |=> (pa_pu == $past(bus_wdata)));

  assert_portc_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (bus_addr == AW'('h02) || bus_addr == AW'('h06) || bus_addr == AW'('h12)))
      |-> (bus_rdata[DW-1:CW] == '0));

  assert_no_read_no_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == '0));

  assert_open_drain_never_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (od_en && dir_c[CW-1]) |-> !(pc_oe[CW-1] && pc_out[CW-1]));

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(irq_en));

  assert_irq_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .pa_oe(pa_oe), .pa_pu(pa_pu), .pc_oe(pc_oe), .pc_out(pc_out),
  .od_en(od_en), .irq_en(irq_en), .dir_c(dir_c), .irq_req(irq_req)
);

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_we, bus_re;
  logic [7:0] pa_in, pa_oe, pa_out, pa_pu;
  logic [7:0] pb_in, pb_oe, pb_out, pb_pu;
  logic [3:0] pc_in, pc_oe, pc_out, pc_pu;
  logic       irq_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_oe(pa_oe), .pa_out(pa_out), .pa_pu(pa_pu),
    .pb_in(pb_in), .pb_oe(pb_oe), .pb_out(pb_out), .pb_pu(pb_pu),
    .pc_in(pc_in), .pc_oe(pc_oe), .pc_out(pc_out), .pc_pu(pc_pu),
    .irq_req(irq_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    settle();
    rd(8'h04, d); check("R1 dir A", d, 0);
    rd(8'h06, d); check("R1 dir C", d, 0);
    rd(8'h10, d); check("R1 pull-up A", d, 0);
    rd(8'h13, d); check("R1 control", d, 0);
    check("R1 oe", {pa_oe, pb_oe, pc_oe}, 0);
    check("R1 pu", {pa_pu, pb_pu, pc_pu}, 0);
    check("R1 irq", irq_req, 0);
  endtask

  task automatic t_output();
    logic [7:0] d;
    wr(8'h04, 8'hFF);
    wr(8'h00, 8'hC3);
    check("R2 oe", pa_oe, 8'hFF);
    check("R2 out", pa_out, 8'hC3);
    @(negedge clk); pa_in = 8'h3C;
    settle();
    rd(8'h00, d); check("R3 latch readback", d, 8'hC3);
    wr(8'h04, 8'h0F);
    check("R2 oe partial", pa_oe, 8'h0F);
    rd(8'h00, d); check("R3/R4 mixed read", d, 8'h33);
  endtask

  task automatic t_input();
    logic [7:0] d;
    @(negedge clk); pb_in = 8'hA5;
    settle();
    rd(8'h01, d); check("R4 input read", d, 8'hA5);
    pb_in = 8'h5A;
    rd(8'h01, d); check("R4 one edge", d, 8'hA5);
    rd(8'h01, d); check("R4 two edges", d, 8'h5A);
  endtask

  task automatic t_preload();
    logic [7:0] d;
    wr(8'h01, 8'h96);
    check("R5 oe stays off", pb_oe, 8'h00);
    rd(8'h01, d); check("R5 read pad", d, 8'h5A);
    wr(8'h05, 8'hFF);
    check("R5 preload driven", pb_out, 8'h96);
    check("R5 oe on", pb_oe, 8'hFF);
    rd(8'h01, d); check("R5 latch read", d, 8'h96);
  endtask

  task automatic t_map();
    logic [7:0] d;
    wr(8'h13, 8'h03);
    rd(8'h13, d); check("R6 control", d, 8'h03);
    wr(8'h13, 8'h00);
    rd(8'h05, d); check("R6 dir B", d, 8'hFF);
    rd(8'h08, d); check("R6 unmapped", d, 8'h00);
    @(negedge clk); bus_addr = 8'h05; bus_re = 1'b0;
    #1 check("R6 no strobe", bus_rdata, 0);
  endtask

  task automatic t_pullup();
    logic [7:0] d;
    wr(8'h10, 8'hA1);
    wr(8'h11, 8'h7E);
    check("R7 pu A", pa_pu, 8'hA1);
    check("R7 pu B", pb_pu, 8'h7E);
    rd(8'h10, d); check("R7 readback", d, 8'hA1);
  endtask

  task automatic t_portc_upper();
    logic [7:0] d;
    wr(8'h06, 8'hF8);
    rd(8'h06, d); check("R8 dir C", d, 8'h08);
    wr(8'h12, 8'hFF);
    rd(8'h12, d); check("R8 pu C", d, 8'h0F);
    check("R8 pu pins", pc_pu, 4'hF);
    wr(8'h02, 8'hF8);
    rd(8'h02, d); check("R8 data C", d, 8'h0F);
  endtask

  task automatic t_open_drain();
    wr(8'h13, 8'h01);
    wr(8'h02, 8'h00);
    check("R9 low drive oe", pc_oe[3], 1);
    check("R9 low drive out", pc_out[3], 0);
    wr(8'h02, 8'h08);
    check("R9 release", pc_oe[3], 0);
    check("R9 pull-up kept", pc_pu[3], 1);
    wr(8'h13, 8'h00);
    check("R9 push-pull oe", pc_oe[3], 1);
    check("R9 push-pull out", pc_out[3], 1);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    int pulses;
    wr(8'h13, 8'h02);
    wr(8'h06, 8'h00);
    rd(8'h06, d); check("R10 dir writable", d, 8'h00);
    @(negedge clk); pc_in = 4'h7;
    @(negedge clk); check("R10 edge1", irq_req, 0);
    @(negedge clk); check("R10 edge2", irq_req, 0);
    @(negedge clk); check("R10 edge3 pulse", irq_req, 1);
    @(negedge clk); check("R10 width", irq_req, 0);
    pc_in = 4'hF; pulses = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += irq_req; end
    check("R10 rising no pulse", pulses, 0);
    wr(8'h13, 8'h00);
    pc_in = 4'h7; pulses = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += irq_req; end
    check("R10 disabled no pulse", pulses, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    pa_in = 8'h5A; pb_in = 8'h00; pc_in = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_output();
    t_input();
    t_preload();
    t_map();
    t_pullup();
    t_portc_upper();
    t_open_drain();
    t_irq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule